// File: doc/BRIEF.md
# Reorder Buffer with In-Order Commit and Fault Flush

This block holds every instruction an out-of-order core has decoded but not yet committed. Each decoded instruction claims the next slot of a circular buffer, in program order, and the slot number it receives becomes the rename tag of its destination register. Execution units report results back by tag in whatever order they finish. Each result carries a value and a fault flag. The oldest slot leaves the buffer only after its result has arrived. A clean result is then written into an internal architectural register file. A faulting result writes nothing. It empties the whole buffer and raises a one-cycle request for the front end to restart at the handler.

A combinational lookup port resolves a source register for decode. If no in-flight instruction will write the register, the port returns the committed value. If one will, it returns the tag of the youngest such writer. The value comes with the tag once that writer has finished, even though it has not committed.

Allocation uses a valid/ready handshake. A slot is taken only in a cycle where `alloc_valid` and `alloc_ready` are both high. `alloc_id` is valid in that cycle, and the requester must hold `alloc_dst` steady until the slot is taken. `alloc_ready` falls when every slot is in use, and also during a flush cycle. Completion writes are never back-pressured: a `cmp_valid` pulse is always accepted. Completions are not forwarded to the lookup port in the same cycle; they become visible one cycle later.

Top module: `rob_top`

## Requirements
- R1: After reset the buffer is empty, `alloc_ready` is 1, `ret_valid` and `flush_req` are 0, and the lookup of any register reports not renamed, ready, value 0.
- R2: Accepted allocations receive consecutive IDs modulo DEPTH (8 by default). The first ID after reset or after a flush is 0, and the sequence wraps from 7 back to 0.
- R3: With DEPTH slots in use, `alloc_ready` is 0 and a held request takes no slot until a slot retires.
- R4: Completions may arrive in any order. Each one stores its value in its own slot, and from the next cycle the lookup of the renamed register reports ready with that value.
- R5: `ret_valid` is high only when the oldest slot has completed without fault. A finished younger slot waits while an older slot is still incomplete.
- R6: At most one slot retires per cycle. `ret_reg` and `ret_value` show the committing slot. From the next cycle its value is the committed value of that register.
- R7: When the oldest completed slot has its fault flag set, `flush_req` is high for that cycle and nothing is committed. In the next cycle the buffer is empty, no register is renamed, and the faulting register keeps its old committed value.
- R8: The lookup returns the tag of the youngest in-flight writer of the register. `lk_ready` is 0 until that writer completes.
- R9: Committing an older writer of a register does not remove the mapping of a younger in-flight writer of the same register.
- R10: Flush takes priority over allocation: `alloc_ready` is 0 in a cycle with `flush_req` high.
- R11: An allocation and a commit in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Decode requests a slot |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_dst | input | log2(NREG) | Destination register of the new instruction |
| alloc_id | output | log2(DEPTH) | Tag given to the new instruction |
| cmp_valid | input | 1 | A result is being written back |
| cmp_id | input | log2(DEPTH) | Tag of the finishing instruction |
| cmp_value | input | DW | Result value |
| cmp_exc | input | 1 | Result faulted |
| lk_reg | input | log2(NREG) | Source register to resolve |
| lk_renamed | output | 1 | Register has an in-flight writer |
| lk_tag | output | log2(DEPTH) | Tag of the youngest in-flight writer |
| lk_ready | output | 1 | `lk_value` holds the current value |
| lk_value | output | DW | Committed or finished in-flight value |
| ret_valid | output | 1 | Oldest slot commits this cycle |
| ret_reg | output | log2(NREG) | Register being committed |
| ret_value | output | DW | Value being committed |
| flush_req | output | 1 | Fault at the oldest slot: buffer flushed, redirect to handler |

## Verification
The main coincidence is an allocation that lands in the same cycle as a commit. Both operations then move the pointers and both touch the rename map. A second case is a commit of an older writer of a register while a younger writer of that register is still in flight. The stimulus table creates both cases on purpose. The bench judges them at the lookup port, by checking that the younger tag survives. It also checks that the freshly allocated ID follows in sequence. A fault with an allocation held at the same time checks that flush wins: no slot is taken, and the next ID is 0.

// File: rtl/rob_pkg.sv
package rob_pkg;
  localparam int ROB_DEPTH = 8;
  localparam int ARCH_REGS = 8;
  localparam int DATA_W    = 16;

  // What the oldest slot does in the current cycle
  typedef enum logic [1:0] {
    HEAD_IDLE   = 2'd0,
    HEAD_COMMIT = 2'd1,
    HEAD_FAULT  = 2'd2
  } head_act_e;
endpackage

// File: rtl/rob_ptr_ctl.sv
module rob_ptr_ctl #(
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic                     pop,
  input  logic                     flush,
  output logic [$clog2(DEPTH):0]   head,
  output logic [$clog2(DEPTH):0]   tail,
  output logic                     full,
  output logic                     empty
);
  localparam int IW = $clog2(DEPTH);

  logic [IW:0] used;

  // One wrap bit above the index separates full from empty
  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      head <= '0;
      tail <= '0;
    end else begin
      head <= head + (IW+1)'(pop);
      tail <= tail + (IW+1)'(push);
    end
  end

  assign used  = tail - head;
  assign empty = (used == '0);
  assign full  = (used == (IW+1)'(DEPTH));
endmodule

// File: rtl/rob_entries.sv
module rob_entries #(
  parameter int DEPTH = 8,
  parameter int RW    = 3,
  parameter int DW    = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [$clog2(DEPTH)-1:0]  wr_idx,
  input  logic [RW-1:0]             wr_dst,
  input  logic                      cmp_en,
  input  logic [$clog2(DEPTH)-1:0]  cmp_idx,
  input  logic [DW-1:0]             cmp_val,
  input  logic                      cmp_exc,
  input  logic [$clog2(DEPTH)-1:0]  head_idx,
  input  logic [$clog2(DEPTH)-1:0]  rd_idx,
  output logic                      head_done,
  output logic                      head_exc,
  output logic [RW-1:0]             head_dst,
  output logic [DW-1:0]             head_val,
  output logic                      rd_done,
  output logic [DW-1:0]             rd_val
);
  logic [DEPTH-1:0] done_v;
  logic [DEPTH-1:0] exc_v;
  logic [RW-1:0]    dst_a [DEPTH];
  logic [DW-1:0]    val_a [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic          done_q;
    logic          exc_q;
    logic [RW-1:0] dst_q;
    logic [DW-1:0] val_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        done_q <= 1'b0;
        exc_q  <= 1'b0;
        dst_q  <= '0;
        val_q  <= '0;
      end else if (wr_en && wr_idx == e) begin
        done_q <= 1'b0;
        exc_q  <= 1'b0;
        dst_q  <= wr_dst;
      end else if (cmp_en && cmp_idx == e) begin
        done_q <= 1'b1;
        exc_q  <= cmp_exc;
        val_q  <= cmp_val;
      end
    end

    assign done_v[e] = done_q;
    assign exc_v[e]  = exc_q;
    assign dst_a[e]  = dst_q;
    assign val_a[e]  = val_q;
  end

  assign head_done = done_v[head_idx];
  assign head_exc  = exc_v[head_idx];
  assign head_dst  = dst_a[head_idx];
  assign head_val  = val_a[head_idx];
  assign rd_done   = done_v[rd_idx];
  assign rd_val    = val_a[rd_idx];
endmodule

// File: rtl/rob_regstate.sv
module rob_regstate #(
  parameter int NREG = 8,
  parameter int IW   = 3,
  parameter int DW   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     alloc_en,
  input  logic [$clog2(NREG)-1:0]  alloc_reg,
  input  logic [IW-1:0]            alloc_tag,
  input  logic                     ret_en,
  input  logic [$clog2(NREG)-1:0]  ret_reg,
  input  logic [IW-1:0]            ret_tag,
  input  logic [DW-1:0]            ret_val,
  input  logic [$clog2(NREG)-1:0]  lk_reg,
  output logic                     lk_mapped,
  output logic [IW-1:0]            lk_tag,
  output logic [DW-1:0]            lk_arch
);
  logic [NREG-1:0] map_v;
  logic [IW-1:0]   map_t  [NREG];
  logic [DW-1:0]   arch_a [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic          mv_q;
    logic [IW-1:0] mt_q;
    logic [DW-1:0] arch_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        arch_q <= '0;
      end else if (ret_en && ret_reg == r) begin
        arch_q <= ret_val;
      end
    end

    // Newest writer wins; a commit clears only its own mapping
    always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
        mv_q <= 1'b0;
        mt_q <= '0;
      end else if (alloc_en && alloc_reg == r) begin
        mv_q <= 1'b1;
        mt_q <= alloc_tag;
      end else if (ret_en && ret_reg == r && mv_q && mt_q == ret_tag) begin
        mv_q <= 1'b0;
      end
    end

    assign map_v[r]  = mv_q;
    assign map_t[r]  = mt_q;
    assign arch_a[r] = arch_q;
  end

  assign lk_mapped = map_v[lk_reg];
  assign lk_tag    = map_t[lk_reg];
  assign lk_arch   = arch_a[lk_reg];
endmodule

// File: rtl/rob_top.sv
module rob_top
  import rob_pkg::*;
#(
  parameter int DEPTH = ROB_DEPTH,
  parameter int NREG  = ARCH_REGS,
  parameter int DW    = DATA_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      alloc_valid,
  output logic                      alloc_ready,
  input  logic [$clog2(NREG)-1:0]   alloc_dst,
  output logic [$clog2(DEPTH)-1:0]  alloc_id,
  input  logic                      cmp_valid,
  input  logic [$clog2(DEPTH)-1:0]  cmp_id,
  input  logic [DW-1:0]             cmp_value,
  input  logic                      cmp_exc,
  input  logic [$clog2(NREG)-1:0]   lk_reg,
  output logic                      lk_renamed,
  output logic [$clog2(DEPTH)-1:0]  lk_tag,
  output logic                      lk_ready,
  output logic [DW-1:0]             lk_value,
  output logic                      ret_valid,
  output logic [$clog2(NREG)-1:0]   ret_reg,
  output logic [DW-1:0]             ret_value,
  output logic                      flush_req
);
  localparam int IW = $clog2(DEPTH);
  localparam int RW = $clog2(NREG);

  logic [IW:0]   head_ptr;
  logic [IW:0]   tail_ptr;
  logic          full;
  logic          empty;
  logic          alloc_fire;
  logic          head_done;
  logic          head_exc;
  logic [RW-1:0] head_dst;
  logic [DW-1:0] head_val;
  logic          rd_done;
  logic [DW-1:0] rd_val;
  logic [DW-1:0] arch_val;
  head_act_e     head_act;

  always_comb begin
    head_act = HEAD_IDLE;
    if (!empty && head_done)
      head_act = head_exc ? HEAD_FAULT : HEAD_COMMIT;
  end

  assign ret_valid   = (head_act == HEAD_COMMIT);
  assign flush_req   = (head_act == HEAD_FAULT);
  assign ret_reg     = head_dst;
  assign ret_value   = head_val;
  assign alloc_ready = !full && !flush_req;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_id    = tail_ptr[IW-1:0];

  rob_ptr_ctl #(.DEPTH(DEPTH)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (alloc_fire),
    .pop   (ret_valid),
    .flush (flush_req),
    .head  (head_ptr),
    .tail  (tail_ptr),
    .full  (full),
    .empty (empty)
  );

  rob_entries #(.DEPTH(DEPTH), .RW(RW), .DW(DW)) u_ent (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (alloc_fire),
    .wr_idx    (tail_ptr[IW-1:0]),
    .wr_dst    (alloc_dst),
    .cmp_en    (cmp_valid),
    .cmp_idx   (cmp_id),
    .cmp_val   (cmp_value),
    .cmp_exc   (cmp_exc),
    .head_idx  (head_ptr[IW-1:0]),
    .rd_idx    (lk_tag),
    .head_done (head_done),
    .head_exc  (head_exc),
    .head_dst  (head_dst),
    .head_val  (head_val),
    .rd_done   (rd_done),
    .rd_val    (rd_val)
  );

  rob_regstate #(.NREG(NREG), .IW(IW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush_req),
    .alloc_en  (alloc_fire),
    .alloc_reg (alloc_dst),
    .alloc_tag (tail_ptr[IW-1:0]),
    .ret_en    (ret_valid),
    .ret_reg   (head_dst),
    .ret_tag   (head_ptr[IW-1:0]),
    .ret_val   (head_val),
    .lk_reg    (lk_reg),
    .lk_mapped (lk_renamed),
    .lk_tag    (lk_tag),
    .lk_arch   (arch_val)
  );

  assign lk_ready = !lk_renamed || rd_done;
  assign lk_value = lk_renamed ? rd_val : arch_val;
endmodule

// File: rtl/rob_chk.sv
module rob_chk #(
  parameter int DEPTH = 8,
  parameter int IW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          alloc_valid,
  input logic          alloc_ready,
  input logic [IW-1:0] alloc_id,
  input logic          ret_valid,
  input logic          flush_req,
  input logic [IW:0]   head_ptr,
  input logic [IW:0]   tail_ptr
);
  logic [IW:0] used;
  assign used = tail_ptr - head_ptr;

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    used <= (IW+1)'(DEPTH));

  a_r2_next_id: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready && !flush_req) |=>
      tail_ptr[IW-1:0] == $past(alloc_id) + IW'(1));

  a_r6_single_retire: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> head_ptr == $past(head_ptr) + (IW+1)'(1));

  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> (head_ptr == tail_ptr));

  a_r5_no_retire_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (head_ptr == tail_ptr) |-> !ret_valid && !flush_req);
endmodule

bind rob_top rob_chk #(.DEPTH(DEPTH), .IW(IW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .alloc_valid (alloc_valid),
  .alloc_ready (alloc_ready),
  .alloc_id    (alloc_id),
  .ret_valid   (ret_valid),
  .flush_req   (flush_req),
  .head_ptr    (head_ptr),
  .tail_ptr    (tail_ptr)
);

// File: tb/rob_top_tb_top.sv
module rob_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 1'b0;
  logic        alloc_ready;
  logic [2:0]  alloc_dst = '0;
  logic [2:0]  alloc_id;
  logic        cmp_valid = 1'b0;
  logic [2:0]  cmp_id = '0;
  logic [15:0] cmp_value = '0;
  logic        cmp_exc = 1'b0;
  logic [2:0]  lk_reg = '0;
  logic        lk_renamed;
  logic [2:0]  lk_tag;
  logic        lk_ready;
  logic [15:0] lk_value;
  logic        ret_valid;
  logic [2:0]  ret_reg;
  logic [15:0] ret_value;
  logic        flush_req;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  rob_top dut_i (.*);

  typedef struct packed {
    logic        av;
    logic [2:0]  ad;
    logic        cv;
    logic [2:0]  ci;
    logic [15:0] cval;
    logic        ce;
    logic [2:0]  lr;
    logic [2:0]  e_aid;
    logic        e_ardy;
    logic        e_rv;
    logic [15:0] e_rval;
    logic        e_fl;
    logic        e_lrdy;
    logic [15:0] e_lval;
  } vec_t;

  // One row per cycle: inputs, then outputs expected before the edge
  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 3'd1, 1'b0, 3'd0, 16'h0000, 1'b0, 3'd1, 3'd0, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0000},
    '{1'b1, 3'd2, 1'b0, 3'd0, 16'h0000, 1'b0, 3'd1, 3'd1, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000},
    '{1'b1, 3'd1, 1'b1, 3'd1, 16'h0022, 1'b0, 3'd2, 3'd2, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000},
    '{1'b0, 3'd0, 1'b1, 3'd0, 16'h0011, 1'b0, 3'd2, 3'd0, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0022},
    '{1'b0, 3'd0, 1'b0, 3'd0, 16'h0000, 1'b0, 3'd1, 3'd0, 1'b1, 1'b1, 16'h0011, 1'b0, 1'b0, 16'h0000},
    '{1'b0, 3'd0, 1'b0, 3'd0, 16'h0000, 1'b0, 3'd1, 3'd0, 1'b1, 1'b1, 16'h0022, 1'b0, 1'b0, 16'h0000},
    '{1'b0, 3'd0, 1'b1, 3'd2, 16'h0033, 1'b0, 3'd2, 3'd0, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0022},
    '{1'b1, 3'd3, 1'b0, 3'd0, 16'h0000, 1'b0, 3'd1, 3'd3, 1'b1, 1'b1, 16'h0033, 1'b0, 1'b1, 16'h0033},
    '{1'b0, 3'd0, 1'b0, 3'd0, 16'h0000, 1'b0, 3'd1, 3'd0, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0033},
    '{1'b0, 3'd0, 1'b1, 3'd3, 16'h0044, 1'b1, 3'd3, 3'd0, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000},
    '{1'b1, 3'd4, 1'b0, 3'd0, 16'h0000, 1'b0, 3'd4, 3'd0, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b1, 16'h0000},
    '{1'b1, 3'd5, 1'b0, 3'd0, 16'h0000, 1'b0, 3'd3, 3'd0, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0000}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Apply inputs after a falling edge, settle, then checks may run
  task automatic drive(input logic av, input logic [2:0] ad, input logic cv,
                       input logic [2:0] ci, input logic [15:0] cval,
                       input logic ce, input logic [2:0] lr);
    @(negedge clk);
    alloc_valid = av; alloc_dst = ad;
    cmp_valid = cv; cmp_id = ci; cmp_value = cval; cmp_exc = ce;
    lk_reg = lr;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: state straight out of reset
    drive(0, 0, 0, 0, 0, 0, 3'd1);
    check("R1", "alloc_ready", alloc_ready, 1);
    check("R1", "ret_valid", ret_valid, 0);
    check("R1", "flush_req", flush_req, 0);
    check("R1", "lk_renamed", lk_renamed, 0);
    check("R1", "lk_ready", lk_ready, 1);

    // Table walk: R2 R4 R5 R6 R7 R8 R9 R10 R11
    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].av, TBL[i].ad, TBL[i].cv, TBL[i].ci, TBL[i].cval, TBL[i].ce, TBL[i].lr);
      check("R3/R10", $sformatf("v%0d alloc_ready", i), alloc_ready, TBL[i].e_ardy);
      if (TBL[i].av && TBL[i].e_ardy)
        check("R2", $sformatf("v%0d alloc_id", i), alloc_id, TBL[i].e_aid);
      check("R5", $sformatf("v%0d ret_valid", i), ret_valid, TBL[i].e_rv);
      if (TBL[i].e_rv)
        check("R6", $sformatf("v%0d ret_value", i), ret_value, TBL[i].e_rval);
      check("R7", $sformatf("v%0d flush_req", i), flush_req, TBL[i].e_fl);
      check("R4/R8/R9", $sformatf("v%0d lk_ready", i), lk_ready, TBL[i].e_lrdy);
      if (TBL[i].e_lrdy)
        check("R4/R9", $sformatf("v%0d lk_value", i), lk_value, TBL[i].e_lval);
    end
    // R9: at v5 r1 still pointed at tag 2 after tag 0 committed
    drive(0, 0, 0, 0, 0, 0, 3'd5);
    check("R8", "r5 renamed after flush alloc", lk_renamed, 1);
    check("R8", "r5 youngest tag", lk_tag, 0);

    // R1: reset clears committed state
    @(negedge clk); rst_n = 1'b0; alloc_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    drive(0, 0, 0, 0, 0, 0, 3'd1);
    check("R1", "r1 value after reset", lk_value, 0);
    check("R1", "r1 not renamed after reset", lk_renamed, 0);

    // R3: fill every slot
    for (int k = 0; k < 8; k++) begin
      drive(1, 3'(k), 0, 0, 0, 0, 0);
      check("R2", $sformatf("fill id %0d", k), alloc_id, k);
      check("R3", "ready while filling", alloc_ready, 1);
    end
    drive(1, 3'd7, 0, 0, 0, 0, 3'd7);
    check("R3", "ready when full", alloc_ready, 0);
    check("R8", "r7 tag", lk_tag, 7);
    drive(1, 3'd7, 0, 0, 0, 0, 3'd7);
    check("R3", "held request not taken", alloc_ready, 0);

    // R5: complete younger slots first; nothing commits
    for (int k = 7; k >= 1; k--) begin
      drive(0, 0, 1, 3'(k), 16'(16'h100 + k), 0, 3'd7);
      check("R5", $sformatf("no commit before head, id %0d", k), ret_valid, 0);
    end
    drive(0, 0, 1, 3'd0, 16'h0100, 0, 3'd7);
    check("R4", "r7 forwarded before commit", lk_value, 16'h107);
    check("R5", "head still pending", ret_valid, 0);

    // R6: one commit per cycle in program order
    for (int k = 0; k < 8; k++) begin
      drive(0, 0, 0, 0, 0, 0, 3'd7);
      check("R6", $sformatf("commit %0d valid", k), ret_valid, 1);
      check("R6", $sformatf("commit %0d reg", k), ret_reg, k);
      check("R6", $sformatf("commit %0d value", k), ret_value, 16'h100 + k);
    end
    drive(0, 0, 0, 0, 0, 0, 3'd7);
    check("R6", "drained", ret_valid, 0);
    check("R6", "r7 committed", lk_value, 16'h107);
    check("R6", "r7 unmapped", lk_renamed, 0);

    // R2: wrap back to tag 0
    drive(1, 3'd2, 0, 0, 0, 0, 0);
    check("R2", "wrapped id", alloc_id, 0);
    drive(0, 0, 0, 0, 0, 0, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule